// File: doc/BRIEF.md
# DDR2 Write Termination and Read-to-Write Turnaround Controller

This block sits in the command path of a DDR2 memory controller, between the scheduler that proposes commands and the logic that drives them onto the memory bus. Each cycle it receives at most one command request and answers with a same-cycle grant. READ and non-data commands pass straight through. A WRITE is held back when it would come too soon after a READ, or when the configured CAS latency cannot be served. For every granted WRITE it drives the on-die termination control pin, so that termination in the memory is on for the whole write burst.

The termination pulse is one clock longer than the write burst strictly needs. This extension moves the earliest legal WRITE after a READ from four clocks to five, because otherwise returning read data would still be on the bus when the termination turns on. The memory switches termination on two clocks after the pin rises. The pin therefore rises CL-4 clocks after the WRITE, with write latency taken as CL-1 and no additive latency. This delay is only non-negative and non-zero for CL of 5 or more, so smaller CAS latencies are flagged as a configuration error and writes are refused. CAS latency and burst length are treated as static between resets.

Top module: `ddr2_wodt_ctrl`

## Requirements
- R1: `cfg_err` is high in exactly those cycles where `cas_lat`, read as an unsigned CL value in clocks, is below 5.
- R2: While `cfg_err` is high, no WRITE is granted, but READ and other commands are still granted.
- R3: After a READ is granted in cycle r, a WRITE requested in cycles r+1 to r+4 is not granted, and one requested in cycle r+5 or later is granted.
- R4: Command encoding on `req_cmd` is 2'b01 READ, 2'b10 WRITE, and 2'b00 or 2'b11 other. A valid READ or other command is granted in the same cycle, outside reset.
- R5: For a WRITE granted in cycle w, `odt_out` is first high in cycle w+CL-4. It is never high in or before cycle w because of that write.
- R6: Each write keeps `odt_out` high for BL/2+1 consecutive cycles. `burst8`=0 selects BL4 (3 cycles) and `burst8`=1 selects BL8 (5 cycles).
- R7: When the high windows of successive writes overlap or are adjacent, `odt_out` stays high without a low cycle and falls exactly one window length after the start of the last window.
- R8: `rst` is synchronous and active high. In a reset cycle no command is granted and `odt_out` is low, and after reset no earlier READ or WRITE affects grants or `odt_out`.
- R9: A valid WRITE with CL of 5 or more and no READ within the last 4 cycles is granted in its request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A command is requested this cycle |
| req_cmd | input | 2 | Command type: 01 READ, 10 WRITE, 00/11 other |
| cas_lat | input | CL_W (4) | CAS latency in clocks |
| burst8 | input | 1 | 0 = burst of 4, 1 = burst of 8 |
| req_grant | output | 1 | Requested command may issue this cycle |
| odt_out | output | 1 | On-die termination control pin level |
| cfg_err | output | 1 | CAS latency too small for write termination |

## Verification
The hardest state to reach is a chain of writes whose termination windows touch or overlap. In that state a later write must stretch the pulse without a low glitch, and this must hold for each CAS latency and burst length. The stimulus spaces writes one clock apart, at exactly one window length apart, and at random gaps from a shift-register sequence. It also interleaves READs, so that WRITEs are requested in each cycle of the turnaround window and the first legal cycle is hit exactly. The bench model keeps a queue of write cycles, derives the expected pin level from the windows those writes open, and compares it with the pin every cycle.

// File: rtl/ddr2_wodt_pkg.sv
package ddr2_wodt_pkg;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_MISC  = 2'b11
  } cmd_e;

  // Clocks from the WRITE command to the rise of the termination pin:
  // write latency (cl-1), minus the memory's turn-on delay, minus one
  // clock so termination is on ahead of the first data beat.
  function automatic int odt_lead(input int cl, input int aond);
    return (cl - 1) - aond - 1;
  endfunction

  // High time of the pin for one write: data clocks plus the extension.
  function automatic int odt_span(input logic bl8, input int ext);
    return (bl8 ? 8 : 4) / 2 + ext;
  endfunction

  // Smallest CAS latency whose lead is at least one clock.
  function automatic int min_cl(input int aond);
    return aond + 3;
  endfunction

endpackage

// File: rtl/rd_wr_spacer.sv
module rd_wr_spacer #(
  parameter int GAP = 5,
  parameter int W   = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_fire,
  output logic wr_block
);
  localparam logic [W-1:0] LOAD = W'(GAP - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (rd_fire)       cnt <= LOAD;
    else if (cnt != '0)     cnt <= cnt - W'(1);
  end

  assign wr_block = (cnt != '0);
endmodule

// File: rtl/wr_launch_pipe.sv
module wr_launch_pipe #(
  parameter int DEPTH  = 11,
  parameter int LEAD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_fire,
  input  logic [LEAD_W-1:0] lead,
  output logic              start
);
  logic [DEPTH-1:0] stage;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic d_in;
    logic q;
    if (g == 0) begin : g_head
      assign d_in = wr_fire;
    end else begin : g_body
      assign d_in = stage[g-1];
    end
    always_ff @(posedge clk) begin
      if (rst) q <= 1'b0;
      else     q <= d_in;
    end
    assign stage[g] = q;
  end

  // Stage i holds a write granted i+1 cycles ago.
  always_comb begin
    start = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (LEAD_W'(i + 1) == lead) start = stage[i];
    end
  end
endmodule

// File: rtl/odt_hold.sv
module odt_hold #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] span,
  output logic         odt
);
  logic [W-1:0] cnt;
  logic [W-1:0] dec;
  logic [W-1:0] fresh;

  assign dec   = (cnt == '0) ? '0 : cnt - W'(1);
  assign fresh = span - W'(1);

  // A new window keeps whichever end lies later, so windows merge.
  always_ff @(posedge clk) begin
    if (rst)        cnt <= '0;
    else if (start) cnt <= (dec > fresh) ? dec : fresh;
    else            cnt <= dec;
  end

  assign odt = start | (cnt != '0);
endmodule

// File: rtl/ddr2_wodt_ctrl.sv
module ddr2_wodt_ctrl
  import ddr2_wodt_pkg::*;
#(
  parameter int CL_W      = 4,
  parameter int RD2WR_GAP = 5,
  parameter int ODT_EXT   = 1,
  parameter int T_AOND    = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [1:0]      req_cmd,
  input  logic [CL_W-1:0] cas_lat,
  input  logic            burst8,
  output logic            req_grant,
  output logic            odt_out,
  output logic            cfg_err
);
  localparam int CL_MIN   = min_cl(T_AOND);
  localparam int PIPE_D   = odt_lead((1 << CL_W) - 1, T_AOND);
  localparam int LEAD_W   = $clog2(PIPE_D + 1);
  localparam int SPAN_MAX = odt_span(1'b1, ODT_EXT);
  localparam int SPAN_W   = $clog2(SPAN_MAX + 1);
  localparam int GAP_W    = $clog2(RD2WR_GAP + 1);

  cmd_e              cmd;
  logic              is_wr;
  logic              cl_ok;
  logic              wr_block;
  logic              wr_fire;
  logic              rd_fire;
  logic              odt_start;
  logic              odt_raw;
  logic [LEAD_W-1:0] lead_sel;
  logic [SPAN_W-1:0] span_sel;

  assign cmd      = cmd_e'(req_cmd);
  assign is_wr    = (cmd == CMD_WRITE);
  assign cl_ok    = (int'(cas_lat) >= CL_MIN);
  assign lead_sel = cl_ok ? LEAD_W'(odt_lead(int'(cas_lat), T_AOND)) : LEAD_W'(1);
  assign span_sel = SPAN_W'(odt_span(burst8, ODT_EXT));

  assign req_grant = req_valid & ~rst & (is_wr ? (~wr_block & cl_ok) : 1'b1);
  assign wr_fire   = req_grant & is_wr;
  assign rd_fire   = req_grant & (cmd == CMD_READ);
  assign cfg_err   = ~cl_ok;
  assign odt_out   = odt_raw & ~rst;

  rd_wr_spacer #(.GAP(RD2WR_GAP), .W(GAP_W)) u_spacer (
    .clk      (clk),
    .rst      (rst),
    .rd_fire  (rd_fire),
    .wr_block (wr_block)
  );

  wr_launch_pipe #(.DEPTH(PIPE_D), .LEAD_W(LEAD_W)) u_pipe (
    .clk     (clk),
    .rst     (rst),
    .wr_fire (wr_fire),
    .lead    (lead_sel),
    .start   (odt_start)
  );

  odt_hold #(.W(SPAN_W)) u_hold (
    .clk   (clk),
    .rst   (rst),
    .start (odt_start),
    .span  (span_sel),
    .odt   (odt_raw)
  );
endmodule

// File: rtl/ddr2_wodt_ctrl_chk.sv
module ddr2_wodt_ctrl_chk #(
  parameter int CL_W      = 4,
  parameter int RD2WR_GAP = 5,
  parameter int ODT_EXT   = 1,
  parameter int T_AOND    = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic [1:0]      req_cmd,
  input logic [CL_W-1:0] cas_lat,
  input logic            burst8,
  input logic            req_grant,
  input logic            odt_out,
  input logic            cfg_err
);
  localparam logic [5:0] SAT = 6'd63;

  logic [5:0] since_wr;
  logic [5:0] since_rd;
  logic       wr_ok;
  logic       rd_ok;
  int         lead_i;
  int         span_i;

  assign wr_ok  = req_grant && (req_cmd == 2'b10);
  assign rd_ok  = req_grant && (req_cmd == 2'b01);
  assign lead_i = int'(cas_lat) - (T_AOND + 2);
  assign span_i = (burst8 ? 4 : 2) + ODT_EXT;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_wr <= SAT;
      since_rd <= SAT;
    end else begin
      since_wr <= wr_ok ? 6'd1 : ((since_wr == SAT) ? SAT : since_wr + 6'd1);
      since_rd <= rd_ok ? 6'd1 : ((since_rd == SAT) ? SAT : since_rd + 6'd1);
    end
  end

  p_rd_spacing_r3: assert property (@(posedge clk) disable iff (rst)
    wr_ok |-> (int'(since_rd) >= RD2WR_GAP));

  p_err_no_wr_r2: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !wr_ok);

  p_reset_quiet_r8: assert property (@(posedge clk)
    rst |-> (!req_grant && !odt_out));

  p_grant_needs_req_r4: assert property (@(posedge clk) disable iff (rst)
    req_grant |-> req_valid);

  p_rise_after_wr_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(odt_out) |-> (since_wr >= 6'd1 && int'(since_wr) <= lead_i));

  p_fall_timing_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(odt_out) |-> (int'(since_wr) == lead_i + span_i || int'(since_wr) < lead_i));
endmodule

bind ddr2_wodt_ctrl ddr2_wodt_ctrl_chk #(
  .CL_W(CL_W), .RD2WR_GAP(RD2WR_GAP), .ODT_EXT(ODT_EXT), .T_AOND(T_AOND)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
  .cas_lat(cas_lat), .burst8(burst8), .req_grant(req_grant),
  .odt_out(odt_out), .cfg_err(cfg_err)
);

// File: tb/ddr2_wodt_ctrl_test.sv
`timescale 1ns/1ps
module ddr2_wodt_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [1:0] req_cmd = 2'b00;
  logic [3:0] cas_lat = 4'd5;
  logic       burst8 = 1'b0;
  logic       req_grant, odt_out, cfg_err;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int last_rd = -1000;
  int wr_q[$];
  logic [15:0] lf = 16'hACE1;

  always #2.5 clk = ~clk;

  ddr2_wodt_ctrl uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
    .cas_lat(cas_lat), .burst8(burst8), .req_grant(req_grant),
    .odt_out(odt_out), .cfg_err(cfg_err)
  );

  function automatic bit model_odt(int c);
    int lead = int'(cas_lat) - 4;
    int len  = (burst8 ? 8 : 4) / 2 + 1;
    foreach (wr_q[i]) begin
      if (c >= wr_q[i] + lead && c < wr_q[i] + lead + len) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic check(input logic act, input logic exp, input string tag, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", tag, what, cyc, act, exp);
    end
  endtask

  // One cycle: drive inputs after the falling edge, sample 1 ns later.
  task automatic step(input bit v, input logic [1:0] c, input bit r);
    bit e_err, e_gnt, e_odt;
    string gtag;
    @(negedge clk);
    rst = r; req_valid = v; req_cmd = c;
    #1;
    cyc++;
    e_err = (cas_lat < 4'd5);
    if (r) begin
      e_gnt = 1'b0; e_odt = 1'b0; gtag = "R8";
    end else begin
      e_odt = model_odt(cyc);
      if (c == 2'b10) begin
        if (e_err)                 begin e_gnt = 1'b0; gtag = "R2"; end
        else if (cyc - last_rd < 5) begin e_gnt = 1'b0; gtag = "R3"; end
        else                       begin e_gnt = v;    gtag = "R9"; end
      end else begin
        e_gnt = v; gtag = "R4";
      end
    end
    check(cfg_err, e_err, "R1", "cfg_err");
    check(req_grant, e_gnt, gtag, "req_grant");
    check(odt_out, e_odt, r ? "R8" : "R5 R6 R7", "odt_out");
    if (r) begin
      wr_q.delete();
      last_rd = -1000;
    end else if (e_gnt) begin
      if (c == 2'b01) last_rd = cyc;
      if (c == 2'b10) wr_q.push_back(cyc);
    end
    while (wr_q.size() > 0 && wr_q[0] + 24 < cyc) void'(wr_q.pop_front());
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 2'b00, 1'b0);
  endtask

  task automatic setup(input int cl, input bit b8);
    @(negedge clk);
    cas_lat = 4'(cl); burst8 = b8;
    step(1'b0, 2'b00, 1'b1);
    step(1'b1, 2'b10, 1'b1);
    idle(2);
  endtask

  task automatic random_run(input int n);
    for (int i = 0; i < n; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0], lf[2:1], 1'b0);
    end
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_run();
  end

  initial begin
    for (int cl = 5; cl <= 7; cl++) begin
      for (int b = 0; b < 2; b++) begin
        int len = (b != 0) ? 5 : 3;
        setup(cl, b[0]);
        // R5 R6: lone write
        step(1'b1, 2'b10, 1'b0); idle(14);
        // R7: overlapping windows, writes one clock apart
        step(1'b1, 2'b10, 1'b0); idle(1); step(1'b1, 2'b10, 1'b0); idle(14);
        // R7: adjacent windows, second write exactly one window later
        step(1'b1, 2'b10, 1'b0); idle(len - 1); step(1'b1, 2'b10, 1'b0); idle(14);
        // R3 R9: write requested every cycle after a read
        step(1'b1, 2'b01, 1'b0);
        for (int k = 0; k < 7; k++) step(1'b1, 2'b10, 1'b0);
        idle(14);
        // R4: other commands inside the turnaround window
        step(1'b1, 2'b01, 1'b0); step(1'b1, 2'b00, 1'b0); step(1'b1, 2'b11, 1'b0);
        step(1'b1, 2'b01, 1'b0); idle(6); step(1'b1, 2'b10, 1'b0); idle(14);
        // R8: reset while a window is pending
        step(1'b1, 2'b10, 1'b0); step(1'b0, 2'b00, 1'b1); idle(12);
        random_run(200);
        idle(14);
      end
    end
    // R1 R2: CAS latencies that cannot be served
    for (int cl = 3; cl <= 4; cl++) begin
      setup(cl, 1'b0);
      step(1'b1, 2'b10, 1'b0); step(1'b1, 2'b10, 1'b0);
      step(1'b1, 2'b01, 1'b0); step(1'b1, 2'b11, 1'b0);
      idle(8); step(1'b1, 2'b10, 1'b0); idle(8);
      random_run(60);
    end
    finish_run();
  end
endmodule